// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block turns a PLL parameter word, a strap word and a clock-select word into two frequencies in hertz: the PLL output frequency and the APB bus frequency derived from it. A single-cycle `start` pulse captures the three words and the format select. The block then works through a fixed sequence of integer divides on one shared restoring divider that produces one quotient bit per cycle. When it finishes, it raises `done` for one cycle. Both results stay on the outputs until the next calculation completes.

Two PLL word layouts are supported. The packed layout carries three fields, P, M and N. The legacy layout carries N, OD and D fields and a "programmed" flag. When the legacy word is not programmed, the frequency comes from a small strap-indexed table. Firmware models, clock-tree sanity checkers and boot sequencers use the block to learn the running bus rate without generating any real clock.

Top module: `pll_freq_calc`

## Requirements
- R1: The reference clock is 25 000 000 Hz when strap bit 23 is set. Otherwise it is 48 000 000 Hz when strap bit 18 is set. Otherwise it is 24 000 000 Hz. Bit 23 wins when both are set.
- R2: When PLL word bit 19 (power-down) is set, in either layout, both `pll_hz` and `apb_hz` report 0.
- R3: When bit 20 (bypass) is set, the multiplier is 1 and `pll_hz` equals the reference clock. This applies in the packed layout, and in the legacy layout when the programmed bit 21 is also set.
- R4: Packed layout (`fmt_sel`=1), with P in bits [18:13], M in bits [12:5] and N in bits [4:0]: `pll_hz` = ref × floor(floor((M+1)/(N+1))/(P+1)). Results above 2^32 are kept exactly.
- R5: Legacy layout (`fmt_sel`=0) with bit 21 set, with N in bits [10:5], OD in bit 4 and D in bits [3:0]: `pll_hz` = ref × (2−OD) × floor((N+2)/(D+1)). The doubling is applied after the truncating divide.
- R6: Legacy layout with bit 21 clear: `pll_hz` = table[row][sel] × 10^6. The row is strap bit 23, the sel is strap bits [9:8], row 0 holds {384,360,336,408} and row 1 holds {400,375,350,425}. This holds regardless of the bypass bit.
- R7: `apb_hz` = floor(floor(`pll_hz`/(F+1))/K). F is `clk_sel_word` bits [25:23]. K is 2 in the legacy layout and 4 in the packed layout.
- R8: `done` is a one-cycle pulse. `busy` is high from the cycle after the accepted start until the edge that raises `done`. The number of edges from the start edge to the `done` edge is 1 + k×41. k is 3 for a packed, non-bypassed, powered word, 2 for a programmed, non-bypassed, powered legacy word, and 1 otherwise.
- R9: A `start` pulse while `busy` is high is ignored. Input changes during a calculation change neither its results nor its timing.
- R10: After reset, `busy`, `done`, `pll_hz` and `apb_hz` are 0. Between `done` pulses the result outputs hold their value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when idle |
| fmt_sel | input | 1 | 1 = packed P/M/N layout, 0 = legacy layout |
| pll_word | input | 32 | PLL parameter word |
| strap_word | input | 32 | Strap word (reference select, table select) |
| clk_sel_word | input | 32 | Clock-select word holding the APB divider field |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| pll_hz | output | 40 | PLL output frequency in Hz |
| apb_hz | output | 40 | APB frequency in Hz |

## Verification
A wrong sequencer state changes how many 41-cycle divide passes run. That shows as `done` arriving a whole pass early or late, so the per-cycle comparison of `busy` and `done` catches it at the first differing edge. A slip inside the divider, such as an off-by-one iteration count or a bad restore, corrupts a quotient. That surfaces in `pll_hz` or `apb_hz` at the very next `done`. Cases are chosen where the truncation order or the doubling point changes the answer, so that such slips cannot hide.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DIV1,
    ST_DIV2,
    ST_DIVA
  } calc_state_t;

  // strap table entries in MHz; row picks the 25 MHz reference
  function automatic logic [8:0] strap_mhz(input logic row25, input logic [1:0] sel);
    logic [8:0] v;
    case ({row25, sel})
      3'b000:  v = 9'd384;
      3'b001:  v = 9'd360;
      3'b010:  v = 9'd336;
      3'b011:  v = 9'd408;
      3'b100:  v = 9'd400;
      3'b101:  v = 9'd375;
      3'b110:  v = 9'd350;
      default: v = 9'd425;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pll_calc_div.sv
module pll_calc_div #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W:0]    shifted, trial;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, den_q};
    rem_d   = rem_q;
    quo_d   = quo_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    if (go) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (!trial[W]) begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      den_q <= den_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign quo  = quo_q;
endmodule

// File: rtl/pll_calc_decode.sv
module pll_calc_decode
  import pll_calc_pkg::*;
#(
  parameter int HZ_W      = 40,
  parameter int REG_W     = 32,
  parameter int OFF_BIT   = 19,
  parameter int BYP_BIT   = 20,
  parameter int PROG_BIT  = 21,
  parameter int S25_BIT   = 23,
  parameter int S48_BIT   = 18,
  parameter int SEL_LSB   = 8,
  parameter int PCLK_LSB  = 23,
  parameter int PCLK_W    = 3
) (
  input  logic              fmt,
  input  logic [REG_W-1:0]  pll_w,
  input  logic [REG_W-1:0]  strap_w,
  input  logic [REG_W-1:0]  csel_w,
  output logic [HZ_W-1:0]   ref_hz,
  output logic [HZ_W-1:0]   table_hz,
  output logic              pwr_off,
  output logic              bypass,
  output logic              use_table,
  output logic              od,
  output logic [8:0]        first_num,
  output logic [5:0]        first_den,
  output logic [6:0]        p_plus1,
  output logic [PCLK_W:0]   pclk_plus1
);
  logic [8:0] mhz;
  logic       unused_bits;

  always_comb begin
    if (strap_w[S25_BIT])      ref_hz = HZ_W'(32'd25_000_000);
    else if (strap_w[S48_BIT]) ref_hz = HZ_W'(32'd48_000_000);
    else                       ref_hz = HZ_W'(32'd24_000_000);
  end

  assign mhz       = strap_mhz(strap_w[S25_BIT], strap_w[SEL_LSB +: 2]);
  assign table_hz  = {{(HZ_W-9){1'b0}}, mhz} * HZ_W'(32'd1_000_000);
  assign pwr_off   = pll_w[OFF_BIT];
  assign use_table = !fmt && !pll_w[PROG_BIT];
  assign bypass    = pll_w[BYP_BIT];
  assign od        = pll_w[4];
  assign p_plus1   = {1'b0, pll_w[18:13]} + 7'd1;
  assign pclk_plus1 = {1'b0, csel_w[PCLK_LSB +: PCLK_W]} + 1'b1;

  always_comb begin
    if (fmt) begin
      first_num = {1'b0, pll_w[12:5]} + 9'd1;
      first_den = {1'b0, pll_w[4:0]} + 6'd1;
    end else begin
      first_num = {3'b0, pll_w[10:5]} + 9'd2;
      first_den = {2'b0, pll_w[3:0]} + 6'd1;
    end
  end

  assign unused_bits = ^{pll_w, strap_w, csel_w};
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int HZ_W     = 40,
  parameter int REG_W    = 32,
  parameter int PCLK_LSB = 23,
  parameter int PCLK_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fmt_sel,
  input  logic [REG_W-1:0] pll_word,
  input  logic [REG_W-1:0] strap_word,
  input  logic [REG_W-1:0] clk_sel_word,
  output logic             busy,
  output logic             done,
  output logic [HZ_W-1:0]  pll_hz,
  output logic [HZ_W-1:0]  apb_hz
);
  localparam int MUL_W = 10;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  calc_state_t      state_q, state_d;
  logic             cap_en, out_en, fmt_q;
  logic [REG_W-1:0] pll_q, strap_q, csel_q;
  logic [HZ_W-1:0]  acc_q, acc_d, pll_hz_q, apb_hz_q, apb_d;
  logic             done_q;

  logic [HZ_W-1:0]  ref_hz, table_hz;
  logic             pwr_off, bypass, use_table, od;
  logic [8:0]       first_num;
  logic [5:0]       first_den;
  logic [6:0]       p_plus1;
  logic [PCLK_W:0]  pclk_plus1;

  logic             div_go, div_busy;
  logic [HZ_W-1:0]  div_num, div_den, div_quo;
  logic [MUL_W-1:0] mult;
  logic [HZ_W+MUL_W-1:0] prod;
  logic             unused_quo;

  pll_calc_decode #(.HZ_W(HZ_W), .REG_W(REG_W), .PCLK_LSB(PCLK_LSB), .PCLK_W(PCLK_W)) u_dec (
    .fmt(fmt_q), .pll_w(pll_q), .strap_w(strap_q), .csel_w(csel_q),
    .ref_hz(ref_hz), .table_hz(table_hz), .pwr_off(pwr_off), .bypass(bypass),
    .use_table(use_table), .od(od), .first_num(first_num), .first_den(first_den),
    .p_plus1(p_plus1), .pclk_plus1(pclk_plus1)
  );

  pll_calc_div #(.W(HZ_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .go(div_go), .num(div_num), .den(div_den),
    .busy(div_busy), .quo(div_quo)
  );

  // multiplier source: legacy doubling after the first divide, packed after the second
  always_comb begin
    mult = '0;
    if (state_q == ST_DIV2)
      mult = div_quo[MUL_W-1:0];
    else if (state_q == ST_DIV1 && !fmt_q)
      mult = od ? div_quo[MUL_W-1:0] : {div_quo[MUL_W-2:0], 1'b0};
  end

  assign prod  = {{MUL_W{1'b0}}, ref_hz} * {{HZ_W{1'b0}}, mult};
  assign apb_d = fmt_q ? (div_quo >> 2) : (div_quo >> 1);
  assign unused_quo = ^{prod[HZ_W+MUL_W-1:HZ_W], div_quo[1:0]};

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    out_en  = 1'b0;
    div_go  = 1'b0;
    div_num = '0;
    div_den = '0;
    acc_d   = acc_q;
    case (state_q)
      ST_IDLE: if (start) begin
        cap_en  = 1'b1;
        state_d = ST_SETUP;
      end
      ST_SETUP: begin
        div_go = 1'b1;
        if (pwr_off || use_table || bypass) begin
          if (pwr_off)        acc_d = '0;
          else if (use_table) acc_d = table_hz;
          else                acc_d = ref_hz;
          div_num = acc_d;
          div_den = {{(HZ_W-PCLK_W-1){1'b0}}, pclk_plus1};
          state_d = ST_DIVA;
        end else begin
          div_num = {{(HZ_W-9){1'b0}}, first_num};
          div_den = {{(HZ_W-6){1'b0}}, first_den};
          state_d = ST_DIV1;
        end
      end
      ST_DIV1: if (!div_busy) begin
        div_go = 1'b1;
        if (fmt_q) begin
          div_num = div_quo;
          div_den = {{(HZ_W-7){1'b0}}, p_plus1};
          state_d = ST_DIV2;
        end else begin
          acc_d   = prod[HZ_W-1:0];
          div_num = acc_d;
          div_den = {{(HZ_W-PCLK_W-1){1'b0}}, pclk_plus1};
          state_d = ST_DIVA;
        end
      end
      ST_DIV2: if (!div_busy) begin
        div_go  = 1'b1;
        acc_d   = prod[HZ_W-1:0];
        div_num = acc_d;
        div_den = {{(HZ_W-PCLK_W-1){1'b0}}, pclk_plus1};
        state_d = ST_DIVA;
      end
      ST_DIVA: if (!div_busy) begin
        out_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      fmt_q    <= 1'b0;
      pll_q    <= '0;
      strap_q  <= '0;
      csel_q   <= '0;
      acc_q    <= '0;
      pll_hz_q <= '0;
      apb_hz_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
      done_q  <= out_en;
      if (cap_en) begin
        fmt_q   <= fmt_sel;
        pll_q   <= pll_word;
        strap_q <= strap_word;
        csel_q  <= clk_sel_word;
      end
      if (out_en) begin
        pll_hz_q <= acc_q;
        apb_hz_q <= apb_d;
      end
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign pll_hz = pll_hz_q;
  assign apb_hz = apb_hz_q;
endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk #(
  parameter int HZ_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [HZ_W-1:0] pll_hz,
  input logic [HZ_W-1:0] apb_hz
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pll_hz) && $stable(apb_hz)));

  assert_apb_le_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (apb_hz <= pll_hz));

  assert_off_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pll_hz == '0) |-> (apb_hz == '0));
endmodule

bind pll_freq_calc pll_freq_calc_chk #(.HZ_W(HZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pll_hz(pll_hz), .apb_hz(apb_hz)
);

// File: tb/pll_freq_calc_bench.sv
module pll_freq_calc_bench;
  localparam int HZ_W = 40;
  localparam int PASS = HZ_W + 1;

  logic clk, rst_n, start, fmt_sel, busy, done;
  logic [31:0] pll_word, strap_word, clk_sel_word;
  logic [HZ_W-1:0] pll_hz, apb_hz;
  int n_tests, n_fail;
  bit finished;

  pll_freq_calc u_pll_freq_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt_sel(fmt_sel),
    .pll_word(pll_word), .strap_word(strap_word), .clk_sel_word(clk_sel_word),
    .busy(busy), .done(done), .pll_hz(pll_hz), .apb_hz(apb_hz)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint e_ref(logic [31:0] s);
    if (s[23]) return 25_000_000;
    if (s[18]) return 48_000_000;
    return 24_000_000;
  endfunction

  function automatic longint e_tbl(logic r, logic [1:0] sel);
    longint t[8] = '{384, 360, 336, 408, 400, 375, 350, 425};
    return t[{r, sel}];
  endfunction

  function automatic longint e_pll(logic f, logic [31:0] w, logic [31:0] s);
    longint c = e_ref(s);
    if (w[19]) return 0;
    if (f) begin
      if (w[20]) return c;
      return c * (((longint'(w[12:5]) + 1) / (longint'(w[4:0]) + 1)) / (longint'(w[18:13]) + 1));
    end
    if (!w[21]) return e_tbl(s[23], s[9:8]) * 1_000_000;
    if (w[20]) return c;
    return c * (2 - longint'(w[4])) * ((longint'(w[10:5]) + 2) / (longint'(w[3:0]) + 1));
  endfunction

  function automatic int e_passes(logic f, logic [31:0] w);
    if (w[19] || w[20]) return 1;
    if (f) return 3;
    return w[21] ? 2 : 1;
  endfunction

  function automatic logic [31:0] w_new(int p, int m, int n, bit off, bit byp);
    return (32'(off) << 19) | (32'(byp) << 20) | (32'(p) << 13) | (32'(m) << 5) | 32'(n);
  endfunction

  function automatic logic [31:0] w_leg(int n, int od, int d, bit prog, bit off, bit byp);
    return (32'(prog) << 21) | (32'(off) << 19) | (32'(byp) << 20) | (32'(n) << 5) | (32'(od) << 4) | 32'(d);
  endfunction

  function automatic logic [31:0] w_strap(bit b25, bit b48, int sel);
    return (32'(b25) << 23) | (32'(b48) << 18) | (32'(sel) << 8);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic f, logic [31:0] pw, logic [31:0] sw, int pclk, bit poke);
    longint ep, ea;
    int lat;
    ep  = e_pll(f, pw, sw);
    ea  = ep / (pclk + 1) / (f ? 4 : 2);
    lat = 1 + e_passes(f, pw) * PASS;
    @(negedge clk);
    fmt_sel = f; pll_word = pw; strap_word = sw; clk_sel_word = 32'(pclk) << 23;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= lat + 1; j++) begin
      chk({tag, " R8 busy"}, longint'(busy), longint'(j < lat));
      chk({tag, " R8 done"}, longint'(done), longint'(j == lat));
      if (j == lat) begin
        chk({tag, " pll_hz"}, longint'(pll_hz), ep);
        chk({tag, " R7 apb_hz"}, longint'(apb_hz), ea);
      end
      if (poke && j == 3) begin
        start = 1'b1; fmt_sel = ~f; pll_word = ~pw; strap_word = ~sw; clk_sel_word = '0;
      end else if (poke && j == 4) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; fmt_sel = 1'b0;
    pll_word = '0; strap_word = '0; clk_sel_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset busy", longint'(busy), 0);
    chk("R10 reset done", longint'(done), 0);
    chk("R10 reset pll_hz", longint'(pll_hz), 0);
    chk("R10 reset apb_hz", longint'(apb_hz), 0);

    run("R1 24M ref", 1'b1, w_new(0, 7, 3, 0, 1), w_strap(0, 0, 0), 0, 0);
    run("R1 48M ref", 1'b1, w_new(0, 7, 3, 0, 1), w_strap(0, 1, 0), 0, 0);
    run("R1 25M wins", 1'b1, w_new(0, 7, 3, 0, 1), w_strap(1, 1, 0), 1, 0);
    run("R2 off packed", 1'b1, w_new(3, 99, 2, 1, 0), w_strap(1, 0, 0), 2, 0);
    run("R2 off legacy", 1'b0, w_leg(30, 1, 3, 1, 1, 0), w_strap(0, 1, 3), 0, 0);
    run("R3 legacy bypass", 1'b0, w_leg(30, 0, 3, 1, 0, 1), w_strap(0, 1, 0), 3, 0);
    run("R4 packed basic", 1'b1, w_new(0, 31, 1, 0, 0), w_strap(0, 0, 0), 1, 0);
    run("R4 packed trunc", 1'b1, w_new(1, 14, 2, 0, 0), w_strap(0, 1, 0), 0, 0);
    run("R4 packed wide", 1'b1, w_new(0, 255, 0, 0, 0), w_strap(1, 0, 0), 7, 0);
    run("R5 legacy od1", 1'b0, w_leg(30, 1, 3, 1, 0, 0), w_strap(0, 0, 0), 0, 0);
    run("R5 legacy od0", 1'b0, w_leg(29, 0, 3, 1, 0, 0), w_strap(1, 0, 0), 4, 0);
    run("R6 table 25M", 1'b0, w_leg(5, 0, 1, 0, 0, 1), w_strap(1, 0, 3), 0, 0);
    run("R6 table 48M", 1'b0, w_leg(0, 0, 0, 0, 0, 0), w_strap(0, 1, 1), 1, 0);
    run("R6 table 24M", 1'b0, w_leg(0, 0, 0, 0, 0, 0), w_strap(0, 0, 2), 5, 0);
    run("R7 apb trunc", 1'b1, w_new(0, 31, 1, 0, 0), w_strap(0, 0, 0), 6, 0);
    run("R9 start while busy", 1'b1, w_new(1, 200, 4, 0, 0), w_strap(0, 1, 0), 2, 1);

    // R10: inputs move without a start; results must stay put
    fmt_sel = 1'b0; pll_word = 32'hFFFF_FFFF; strap_word = '0; clk_sel_word = '1;
    repeat (5) @(negedge clk);
    chk("R10 hold pll_hz", longint'(pll_hz), e_pll(1'b1, w_new(1, 200, 4, 0, 0), w_strap(0, 1, 0)));
    chk("R10 hold done", longint'(done), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule